// File: doc/BRIEF.md
# Periodic Output Impedance Calibration Sequencer

This block holds the digital drive-strength codes for an output driver that has two legs: one that pulls the pad low and one that pulls it high. Each code is a binary-weighted word, and each bit switches in a leg segment of twice the strength of the bit below it. Supply and temperature drift move the real impedance away from its target. For that reason a free-running interval timer starts an evaluation at a fixed period. At each evaluation, every leg reads an up/down indication from an external comparator and moves its code by at most one step.

A new code does not reach the driver in the middle of a transition that the leg is taking part in. Each leg keeps a pending code that records the evaluation result. The pending code is copied to the applied code only in a cycle when that leg is idle, meaning the output is disabled or is driving the level the other leg produces. When evaluations arrive while a leg stays busy, each one works from the pending value. The legs are calibrated and updated independently of each other.

Each leg runs a two-state machine. In SETTLED, pending equals applied. In WAIT, a pending code is waiting for an idle cycle.

The transitions are:
- SETTLED to WAIT when an evaluation produces a code different from the pending one.
- WAIT to WAIT on every evaluation. The pending code is re-stepped, and the copy to the applied code is deferred for that cycle.
- WAIT to SETTLED in any non-evaluation cycle in which the leg is idle. The pending code is copied to the applied code.
- SETTLED to SETTLED otherwise.

Top module: `zcal_sequencer`

## Requirements
- R1: Reset loads the mid-scale code 2^(CODE_W-1) into both applied codes and clears the interval timer.
- R2: Evaluations take place on every INTERVAL-th rising clock edge after reset is released, and at no other edge. The first evaluation is at edge INTERVAL. A code computed at an evaluation edge reaches the applied output no earlier than the following edge.
- R3: An evaluation changes a leg's pending code by at most one step. With the leg idle all the time, the applied code moves by exactly one step for each interval in which the comparator requests a move.
- R4: Codes saturate. Stepping up at all-ones or down at all-zeros leaves the code unchanged and never wraps.
- R5: When a leg's up and down indications are both 0 (on target) or both 1, the evaluation leaves that leg's code unchanged.
- R6: The pull-down code (`pd_code`, the leg that drives zeros) changes only on an edge where, in the cycle before it, `oe` was 0 or `dout` was 1.
- R7: The pull-up code (`pu_code`, the leg that drives ones) changes only on an edge where, in the cycle before it, `oe` was 0 or `dout` was 0.
- R8: Evaluations that fall while a leg is busy accumulate in its pending code. At the first idle non-evaluation cycle that follows, the whole accumulated code is applied at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_up | input | 1 | Comparator: raise pull-down code |
| pd_dn | input | 1 | Comparator: lower pull-down code |
| pu_up | input | 1 | Comparator: raise pull-up code |
| pu_dn | input | 1 | Comparator: lower pull-up code |
| dout | input | 1 | Data value currently being driven |
| oe | input | 1 | Output enable (0 = high impedance) |
| pd_code | output | CODE_W | Applied pull-down leg code |
| pu_code | output | CODE_W | Applied pull-up leg code |

## Verification
The assertions assume that the comparator indications, `dout` and `oe` are synchronous to `clk` and hold known values whenever reset is released. The pending-code checks assume that a comparator result sampled at an evaluation edge is the one that was meant for that evaluation. The bench changes every input only on falling edges and keeps all of them at defined levels from time zero. It also applies each comparator pattern for whole intervals, so every evaluation sees a settled value.

// File: rtl/zcal_pkg.sv
package zcal_pkg;

    typedef enum logic [0:0] {
        LEG_SETTLED = 1'b0,
        LEG_WAIT    = 1'b1
    } leg_state_e;

endpackage

// File: rtl/zcal_interval_timer.sv
module zcal_interval_timer #(
    parameter int INTERVAL = 1024
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick
);
    localparam int CNT_W = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(INTERVAL - 1);

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (cnt == LAST) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    assign tick = (cnt == LAST);
endmodule

// File: rtl/zcal_leg_fsm.sv
module zcal_leg_fsm
    import zcal_pkg::*;
#(
    parameter int CODE_W      = 6,
    parameter bit DRIVES_HIGH = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              cmp_up,
    input  logic              cmp_dn,
    input  logic              dout,
    input  logic              oe,
    output logic [CODE_W-1:0] pend_code,
    output logic [CODE_W-1:0] app_code
);
    localparam logic [CODE_W-1:0] MID  = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] TOP  = '1;
    localparam logic [CODE_W-1:0] BOT  = '0;

    leg_state_e state, state_nx;
    logic              idle;
    logic [CODE_W-1:0] stepped;

    generate
        if (DRIVES_HIGH) begin : g_pullup
            assign idle = !oe || !dout;
        end else begin : g_pulldown
            assign idle = !oe || dout;
        end
    endgenerate

    always_comb begin
        stepped = pend_code;
        if (cmp_up && !cmp_dn && pend_code != TOP) begin
            stepped = pend_code + 1'b1;
        end else if (cmp_dn && !cmp_up && pend_code != BOT) begin
            stepped = pend_code - 1'b1;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            LEG_SETTLED: if (tick && stepped != pend_code) state_nx = LEG_WAIT;
            LEG_WAIT:    if (!tick && idle)                state_nx = LEG_SETTLED;
            default:     state_nx = LEG_SETTLED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= LEG_SETTLED;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_code <= MID;
            app_code  <= MID;
        end else begin
            if (tick) begin
                pend_code <= stepped;
            end
            if (state == LEG_WAIT && state_nx == LEG_SETTLED) begin
                app_code <= pend_code;
            end
        end
    end
endmodule

// File: rtl/zcal_sequencer.sv
module zcal_sequencer #(
    parameter int CODE_W   = 6,
    parameter int INTERVAL = 1024
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pd_up,
    input  logic              pd_dn,
    input  logic              pu_up,
    input  logic              pu_dn,
    input  logic              dout,
    input  logic              oe,
    output logic [CODE_W-1:0] pd_code,
    output logic [CODE_W-1:0] pu_code
);
    logic              eval_tick;
    logic [CODE_W-1:0] pd_pend;
    logic [CODE_W-1:0] pu_pend;

    zcal_interval_timer #(.INTERVAL(INTERVAL)) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .tick (eval_tick)
    );

    zcal_leg_fsm #(.CODE_W(CODE_W), .DRIVES_HIGH(1'b0)) u_pd_leg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (eval_tick),
        .cmp_up   (pd_up),
        .cmp_dn   (pd_dn),
        .dout     (dout),
        .oe       (oe),
        .pend_code(pd_pend),
        .app_code (pd_code)
    );

    zcal_leg_fsm #(.CODE_W(CODE_W), .DRIVES_HIGH(1'b1)) u_pu_leg (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (eval_tick),
        .cmp_up   (pu_up),
        .cmp_dn   (pu_dn),
        .dout     (dout),
        .oe       (oe),
        .pend_code(pu_pend),
        .app_code (pu_code)
    );
endmodule

// File: rtl/zcal_sequencer_chk.sv
module zcal_sequencer_chk #(
    parameter int CODE_W   = 6,
    parameter int INTERVAL = 1024
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pd_up,
    input logic              pd_dn,
    input logic              pu_up,
    input logic              pu_dn,
    input logic              dout,
    input logic              oe,
    input logic              eval_tick,
    input logic [CODE_W-1:0] pd_pend,
    input logic [CODE_W-1:0] pu_pend,
    input logic [CODE_W-1:0] pd_code,
    input logic [CODE_W-1:0] pu_code
);
    localparam int CW = (INTERVAL > 1) ? $clog2(INTERVAL) : 1;
    localparam logic [CODE_W-1:0] MID = CODE_W'(1) << (CODE_W - 1);
    localparam logic [CODE_W-1:0] ONE = CODE_W'(1);

    logic [CW-1:0] ref_cnt;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          ref_cnt <= '0;
        else if (ref_cnt == CW'(INTERVAL-1)) ref_cnt <= '0;
        else                                 ref_cnt <= ref_cnt + 1'b1;
    end

    a_r1_reset_mid: assert property (@(posedge clk)
        !rst_n |=> (pd_code == MID && pu_code == MID));

    a_r2_eval_period: assert property (@(posedge clk) disable iff (!rst_n)
        eval_tick == (ref_cnt == CW'(INTERVAL-1)));

    a_r2_quiet_pending: assert property (@(posedge clk) disable iff (!rst_n)
        !eval_tick |=> ($stable(pd_pend) && $stable(pu_pend)));

    a_r3_pd_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        eval_tick |=> (pd_pend == $past(pd_pend) || pd_pend == $past(pd_pend) + ONE
                       || pd_pend == $past(pd_pend) - ONE));

    a_r3_pu_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        eval_tick |=> (pu_pend == $past(pu_pend) || pu_pend == $past(pu_pend) + ONE
                       || pu_pend == $past(pu_pend) - ONE));

    a_r4_pd_top_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_tick && pd_up && !pd_dn && pd_pend == '1) |=> pd_pend == '1);

    a_r4_pu_bot_sat: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_tick && pu_dn && !pu_up && pu_pend == '0) |=> pu_pend == '0);

    a_r5_pd_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_tick && pd_up == pd_dn) |=> $stable(pd_pend));

    a_r5_pu_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (eval_tick && pu_up == pu_dn) |=> $stable(pu_pend));

    a_r6_pd_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && !dout) |=> $stable(pd_code));

    a_r7_pu_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (oe && dout) |=> $stable(pu_code));

    a_r2_no_early_apply: assert property (@(posedge clk) disable iff (!rst_n)
        eval_tick |=> ($stable(pd_code) && $stable(pu_code)));
endmodule

bind zcal_sequencer zcal_sequencer_chk #(.CODE_W(CODE_W), .INTERVAL(INTERVAL)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pd_up    (pd_up),
    .pd_dn    (pd_dn),
    .pu_up    (pu_up),
    .pu_dn    (pu_dn),
    .dout     (dout),
    .oe       (oe),
    .eval_tick(eval_tick),
    .pd_pend  (pd_pend),
    .pu_pend  (pu_pend),
    .pd_code  (pd_code),
    .pu_code  (pu_code)
);

// File: tb/zcal_sequencer_tb.sv
module zcal_sequencer_tb;
    localparam int CW  = 5;
    localparam int IV  = 64;
    localparam int MID = 16;
    localparam int MAXC = 31;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pd_up = 1'b0, pd_dn = 1'b0, pu_up = 1'b0, pu_dn = 1'b0;
    logic dout = 1'b0, oe = 1'b0;
    logic [CW-1:0] pd_code, pu_code;

    int n_run = 0;
    int n_fail = 0;
    int edge_cnt = 0;

    always #2.5 clk = ~clk;

    zcal_sequencer #(.CODE_W(CW), .INTERVAL(IV)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .pd_up(pd_up), .pd_dn(pd_dn), .pu_up(pu_up), .pu_dn(pu_dn),
        .dout(dout), .oe(oe),
        .pd_code(pd_code), .pu_code(pu_code)
    );

    always @(posedge clk) begin
        if (!rst_n) edge_cnt <= 0;
        else        edge_cnt <= edge_cnt + 1;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        pd_up = 0; pd_dn = 0; pu_up = 0; pu_dn = 0; dout = 0; oe = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // ends at the falling edge after rising edge n (counted since reset release)
    task automatic goto_edge(input int n);
        while (edge_cnt != n) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 pd mid", int'(pd_code), MID);
        chk("R1 pu mid", int'(pu_code), MID);
    endtask

    task automatic t_interval();
        do_reset();
        pd_up = 1; pu_dn = 1;
        goto_edge(IV - 1);
        chk("R2 pd before eval", int'(pd_code), MID);
        goto_edge(IV);
        chk("R2 pd not yet applied", int'(pd_code), MID);
        goto_edge(IV + 1);
        chk("R2 pd applied", int'(pd_code), MID + 1);
        chk("R2 pu applied", int'(pu_code), MID - 1);
        goto_edge(2 * IV);
        chk("R3 pd one step only", int'(pd_code), MID + 1);
        goto_edge(2 * IV + 1);
        chk("R3 pd second step", int'(pd_code), MID + 2);
        chk("R3 pu second step", int'(pu_code), MID - 2);
    endtask

    task automatic t_hold();
        do_reset();
        goto_edge(IV + 1);
        chk("R5 pd on target", int'(pd_code), MID);
        chk("R5 pu on target", int'(pu_code), MID);
        pd_up = 1; pd_dn = 1; pu_up = 1; pu_dn = 1;
        goto_edge(2 * IV + 1);
        chk("R5 pd both set", int'(pd_code), MID);
        chk("R5 pu both set", int'(pu_code), MID);
    endtask

    task automatic t_saturate();
        do_reset();
        pd_up = 1; pu_dn = 1;
        goto_edge(20 * IV + 1);
        chk("R4 pd top", int'(pd_code), MAXC);
        chk("R4 pu bottom", int'(pu_code), 0);
    endtask

    task automatic t_defer_pd();
        do_reset();
        oe = 1; dout = 0; pd_up = 1; pu_up = 1;
        goto_edge(2 * IV + 1);
        chk("R6 pd held while driving zeros", int'(pd_code), MID);
        chk("R7 pu applied while zeros", int'(pu_code), MID + 2);
        dout = 1; pd_up = 0; pu_up = 0;
        goto_edge(2 * IV + 2);
        chk("R8 pd accumulated applied", int'(pd_code), MID + 2);
        chk("R7 pu unchanged", int'(pu_code), MID + 2);
    endtask

    task automatic t_defer_pu();
        do_reset();
        oe = 1; dout = 1; pd_dn = 1; pu_dn = 1;
        goto_edge(IV + 1);
        chk("R6 pd applied while ones", int'(pd_code), MID - 1);
        chk("R7 pu held while driving ones", int'(pu_code), MID);
        oe = 0; pd_dn = 0; pu_dn = 0;
        goto_edge(IV + 2);
        chk("R7 pu applied in high-z", int'(pu_code), MID - 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        t_reset();
        t_interval();
        t_hold();
        t_saturate();
        t_defer_pd();
        t_defer_pu();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule